// File: doc/BRIEF.md
# Override-Queue Path Steering Controller

This block sits beside a processor core while a task is being timed. An external analysis host sends it commands. Some only load state: they queue forced branch outcomes or flush that queue. Others start an observation and return a result: they arm a capture point or measure a cycle span. The block watches the core's fetch and retire addresses. When a fetched conditional branch matches the head of the override queue, the block forces that branch's direction and target in the same cycle, so the core follows the path the host chose.

A capture point fires only after every queued override has been used up. This ties a capture address that repeats, such as a loop body, to one dynamic visit: two overrides that each send a loop back-edge round again make the capture land in the third iteration. A span measurement counts the cycles from the fetch of a start address to the retire of a stop address. Each execution command returns one result word over a valid/ready stream.

Top module: `psc_top`

## Requirements
- R1: After reset, cmd_ready is 1 and res_valid, capt_pulse, err_flag and force_valid are all 0.
- R2: Opcode 1 (queue) appends an override {branch address = cmd_addr_a, target = cmd_addr_b, taken = cmd_taken} to a queue of DEPTH (default 8) entries. While the queue is full, cmd_ready is 0 when cmd_op is 1 and stays 1 for the other opcodes.
- R3: When a branch fetch (fetch_valid and fetch_is_branch) has an address equal to the oldest queued entry, force_valid is 1 in that same cycle, force_taken and force_target carry that entry's fields, and the entry is removed. Entries are consumed in the order they were queued.
- R4: A branch fetch whose address differs from the oldest entry of a non-empty queue sets err_flag from the next cycle. It does not remove the entry or force the branch. err_flag then stays 1 until a flush.
- R5: Opcode 2 (capture) arms cmd_addr_a. The capture fires on a fetch of that address only while the queue is empty. capt_pulse is 1 for exactly the one cycle after that fetch.
- R6: A capture returns one result word with res_kind = 1 and res_data = the armed address, zero-extended.
- R7: Opcode 3 (span) waits for a fetch of cmd_addr_a and then for a retire of cmd_addr_b. It returns res_kind = 0 and res_data = the number of clock cycles from the start fetch to the stop retire (1 when the retire comes in the cycle right after the fetch).
- R8: The span count saturates at 2^CNT_W - 1 and does not wrap.
- R9: A result word stays valid and unchanged until res_ready is 1. cmd_ready is 0 from the acceptance of a capture or span command until its result has been taken.
- R10: Opcode 0 (flush) empties the override queue and clears err_flag.
- R11: A branch fetch while the queue is empty is neither forced nor flagged as an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| cmd_op | input | 2 | 0 flush, 1 queue, 2 capture, 3 span |
| cmd_addr_a | input | ADDR_W | Branch, capture or span start address |
| cmd_addr_b | input | ADDR_W | Override target or span stop address |
| cmd_taken | input | 1 | Override direction |
| fetch_valid | input | 1 | A fetch is observed |
| fetch_pc | input | ADDR_W | Fetched address |
| fetch_is_branch | input | 1 | Fetched instruction is a conditional branch |
| retire_valid | input | 1 | A retire is observed |
| retire_pc | input | ADDR_W | Retired address |
| force_valid | output | 1 | Force the current branch fetch |
| force_taken | output | 1 | Forced direction |
| force_target | output | ADDR_W | Forced next address |
| capt_pulse | output | 1 | Snapshot capture trigger |
| err_flag | output | 1 | Sticky override address mismatch |
| res_valid | output | 1 | Result word present |
| res_ready | input | 1 | Result word taken |
| res_kind | output | 1 | 0 span count, 1 capture completion |
| res_data | output | RES_W | Result value |

## Verification
A corrupted queue pointer or count shows up in the very cycle of the next branch fetch. The wrong target or direction appears on the force outputs, a spurious error flag rises one cycle later, or a capture that should be held back fires early. A wrong controller state shows within one cycle as cmd_ready at the wrong level or as a missing or doubled result word. An off-by-one in the span counter shows only in the returned count, so spans of several lengths and a saturating span are compared exactly.

// File: rtl/psc_pkg.sv
package psc_pkg;

    typedef enum logic [1:0] {
        OP_FLUSH = 2'd0,
        OP_QUEUE = 2'd1,
        OP_CAPT  = 2'd2,
        OP_SPAN  = 2'd3
    } psc_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAPT_WAIT,
        ST_SPAN_WAIT,
        ST_SPAN_RUN,
        ST_RESULT
    } psc_state_e;

endpackage

// File: rtl/psc_ovr_queue.sv
module psc_ovr_queue #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [ADDR_W-1:0] push_next,
    input  logic              push_taken,
    input  logic              pop,
    input  logic              flush,
    output logic              empty,
    output logic              full,
    output logic [ADDR_W-1:0] head_addr,
    output logic [ADDR_W-1:0] head_next,
    output logic              head_taken
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [ADDR_W-1:0] br;
        logic [ADDR_W-1:0] nxt;
        logic              tk;
    } entry_t;

    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    entry_t mem_q [DEPTH];
    entry_t mem_d [DEPTH];
    ctl_t   ctl_q, ctl_d;

    logic do_push, do_pop;

    assign empty = (ctl_q.cnt == '0);
    assign full  = (ctl_q.cnt == CNT_W'(DEPTH));
    assign head_addr  = mem_q[ctl_q.rd].br;
    assign head_next  = mem_q[ctl_q.rd].nxt;
    assign head_taken = mem_q[ctl_q.rd].tk;

    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    always_comb begin
        ctl_d = ctl_q;
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (flush) begin
            ctl_d = '0;
        end else begin
            if (do_push) begin
                mem_d[ctl_q.wr] = '{br: push_addr, nxt: push_next, tk: push_taken};
                ctl_d.wr = ptr_inc(ctl_q.wr);
            end
            if (do_pop) ctl_d.rd = ptr_inc(ctl_q.rd);
            case ({do_push, do_pop})
                2'b10:   ctl_d.cnt = ctl_q.cnt + 1'b1;
                2'b01:   ctl_d.cnt = ctl_q.cnt - 1'b1;
                default: ctl_d.cnt = ctl_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) mem_q[g] <= '0;
                else        mem_q[g] <= mem_d[g];
            end
        end
    endgenerate

endmodule

// File: rtl/psc_span_counter.sv
module psc_span_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] value,
    output logic [CNT_W-1:0] value_plus
);
    localparam logic [CNT_W-1:0] CAP = '1;

    typedef struct packed {
        logic [CNT_W-1:0] v;
    } cnt_t;

    cnt_t st_q, st_d;

    assign value      = st_q.v;
    assign value_plus = (st_q.v == CAP) ? CAP : st_q.v + 1'b1;

    always_comb begin
        st_d = st_q;
        if (clear)    st_d.v = '0;
        else if (inc) st_d.v = value_plus;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/psc_top.sv
module psc_top
    import psc_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32,
    parameter int RES_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr_a,
    input  logic [ADDR_W-1:0] cmd_addr_b,
    input  logic              cmd_taken,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic              fetch_is_branch,
    input  logic              retire_valid,
    input  logic [ADDR_W-1:0] retire_pc,
    output logic              force_valid,
    output logic              force_taken,
    output logic [ADDR_W-1:0] force_target,
    output logic              capt_pulse,
    output logic              err_flag,
    output logic              res_valid,
    input  logic              res_ready,
    output logic              res_kind,
    output logic [RES_W-1:0]  res_data
);

    typedef struct packed {
        psc_state_e        st;
        logic [ADDR_W-1:0] capt_addr;
        logic [ADDR_W-1:0] span_start;
        logic [ADDR_W-1:0] span_stop;
        logic              err;
        logic              pulse;
        logic              rvalid;
        logic              rkind;
        logic [RES_W-1:0]  rdata;
    } ctl_t;

    ctl_t q, d;

    logic              q_empty, q_full, q_head_tk;
    logic [ADDR_W-1:0] q_head_addr, q_head_next;
    logic              br_fetch, hit, miss, accept;
    logic              cnt_clear, cnt_inc;
    logic [CNT_W-1:0]  cnt_val, cnt_plus;
    psc_op_e           op;

    assign op       = psc_op_e'(cmd_op);
    assign br_fetch = fetch_valid && fetch_is_branch && !q_empty;
    assign hit      = br_fetch && (fetch_pc == q_head_addr);
    assign miss     = br_fetch && (fetch_pc != q_head_addr);

    assign cmd_ready = (q.st == ST_IDLE) && !((op == OP_QUEUE) && q_full);
    assign accept    = cmd_valid && cmd_ready;

    psc_ovr_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (accept && (op == OP_QUEUE)),
        .push_addr  (cmd_addr_a),
        .push_next  (cmd_addr_b),
        .push_taken (cmd_taken),
        .pop        (hit),
        .flush      (accept && (op == OP_FLUSH)),
        .empty      (q_empty),
        .full       (q_full),
        .head_addr  (q_head_addr),
        .head_next  (q_head_next),
        .head_taken (q_head_tk)
    );

    psc_span_counter #(.CNT_W(CNT_W)) u_span (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (cnt_clear),
        .inc        (cnt_inc),
        .value      (cnt_val),
        .value_plus (cnt_plus)
    );

    always_comb begin
        d         = q;
        d.pulse   = 1'b0;
        cnt_clear = 1'b0;
        cnt_inc   = 1'b0;
        if (miss) d.err = 1'b1;

        unique case (q.st)
            ST_IDLE: begin
                if (accept) begin
                    unique case (op)
                        OP_FLUSH: d.err = 1'b0;
                        OP_QUEUE: d.st  = ST_IDLE;
                        OP_CAPT: begin
                            d.capt_addr = cmd_addr_a;
                            d.st        = ST_CAPT_WAIT;
                        end
                        OP_SPAN: begin
                            d.span_start = cmd_addr_a;
                            d.span_stop  = cmd_addr_b;
                            d.st         = ST_SPAN_WAIT;
                        end
                        default: d.st = ST_IDLE;
                    endcase
                end
            end
            ST_CAPT_WAIT: begin
                if (fetch_valid && (fetch_pc == q.capt_addr) && q_empty) begin
                    d.pulse  = 1'b1;
                    d.rvalid = 1'b1;
                    d.rkind  = 1'b1;
                    d.rdata  = RES_W'(q.capt_addr);
                    d.st     = ST_RESULT;
                end
            end
            ST_SPAN_WAIT: begin
                if (fetch_valid && (fetch_pc == q.span_start)) begin
                    cnt_clear = 1'b1;
                    d.st      = ST_SPAN_RUN;
                end
            end
            ST_SPAN_RUN: begin
                if (retire_valid && (retire_pc == q.span_stop)) begin
                    d.rvalid = 1'b1;
                    d.rkind  = 1'b0;
                    d.rdata  = RES_W'(cnt_plus);
                    d.st     = ST_RESULT;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            ST_RESULT: begin
                if (res_ready) begin
                    d.rvalid = 1'b0;
                    d.st     = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign force_valid  = hit;
    assign force_taken  = q_head_tk;
    assign force_target = q_head_next;
    assign capt_pulse   = q.pulse;
    assign err_flag     = q.err;
    assign res_valid    = q.rvalid;
    assign res_kind     = q.rkind;
    assign res_data     = q.rdata;

    logic unused_cnt;
    assign unused_cnt = ^cnt_val;

endmodule

// File: rtl/psc_checker.sv
module psc_checker #(
    parameter int RES_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [1:0]       cmd_op,
    input logic             fetch_valid,
    input logic             fetch_is_branch,
    input logic             force_valid,
    input logic             capt_pulse,
    input logic             err_flag,
    input logic             res_valid,
    input logic             res_ready,
    input logic             res_kind,
    input logic [RES_W-1:0] res_data
);

    p_force_on_branch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        force_valid |-> (fetch_valid && fetch_is_branch));

    p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !(cmd_valid && cmd_ready && cmd_op == 2'd0)) |=> err_flag);

    p_capt_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        capt_pulse |=> !capt_pulse);

    p_capt_after_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(capt_pulse) |-> $past(fetch_valid));

    p_capt_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        capt_pulse |-> (res_valid && res_kind));

    p_res_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_kind)));

    p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !cmd_ready);

endmodule

bind psc_top psc_checker #(.RES_W(RES_W)) u_psc_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .cmd_valid       (cmd_valid),
    .cmd_ready       (cmd_ready),
    .cmd_op          (cmd_op),
    .fetch_valid     (fetch_valid),
    .fetch_is_branch (fetch_is_branch),
    .force_valid     (force_valid),
    .capt_pulse      (capt_pulse),
    .err_flag        (err_flag),
    .res_valid       (res_valid),
    .res_ready       (res_ready),
    .res_kind        (res_kind),
    .res_data        (res_data)
);

// File: tb/psc_top_bench.sv
module psc_top_bench;
    localparam int AW = 32;
    localparam int CW = 8;
    localparam int RW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0, cmd_taken = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic [AW-1:0] cmd_addr_a = '0, cmd_addr_b = '0;
    logic          fetch_valid = 1'b0, fetch_is_branch = 1'b0;
    logic [AW-1:0] fetch_pc = '0;
    logic          retire_valid = 1'b0;
    logic [AW-1:0] retire_pc = '0;
    logic          res_ready = 1'b0;
    logic          cmd_ready, force_valid, force_taken, capt_pulse, err_flag;
    logic          res_valid, res_kind;
    logic [AW-1:0] force_target;
    logic [RW-1:0] res_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    psc_top #(.DEPTH(8), .ADDR_W(AW), .CNT_W(CW), .RES_W(RW)) u_psc_top (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr_a(cmd_addr_a), .cmd_addr_b(cmd_addr_b),
        .cmd_taken(cmd_taken), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .fetch_is_branch(fetch_is_branch), .retire_valid(retire_valid),
        .retire_pc(retire_pc), .force_valid(force_valid), .force_taken(force_taken),
        .force_target(force_target), .capt_pulse(capt_pulse), .err_flag(err_flag),
        .res_valid(res_valid), .res_ready(res_ready), .res_kind(res_kind),
        .res_data(res_data)
    );

    // start address, stop address, span length in cycles
    localparam int NV = 5;
    localparam logic [NV-1:0][79:0] SPANS = {
        {32'h0000_1000, 32'h0000_1040, 16'd1},
        {32'h0000_2000, 32'h0000_2010, 16'd2},
        {32'h0000_3000, 32'h0000_3100, 16'd7},
        {32'h0000_4000, 32'h0000_4004, 16'd33},
        {32'h0000_5000, 32'h0000_5abc, 16'd254}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] op, input logic [AW-1:0] a,
                        input logic [AW-1:0] b, input logic tk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr_a = a; cmd_addr_b = b; cmd_taken = tk;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'd0;
    endtask

    task automatic fetch(input logic [AW-1:0] pc, input logic br);
        fetch_valid = 1'b1; fetch_pc = pc; fetch_is_branch = br;
        @(negedge clk);
        fetch_valid = 1'b0; fetch_is_branch = 1'b0;
    endtask

    task automatic take_result();
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
    endtask

    task automatic span(input logic [AW-1:0] s, input logic [AW-1:0] e, input int k,
                        input logic [31:0] exp, input string req);
        send(2'd3, s, e, 1'b0);
        fetch(s, 1'b0);
        repeat (k - 1) @(negedge clk);
        retire_valid = 1'b1; retire_pc = e;
        @(negedge clk);
        retire_valid = 1'b0;
        check({req, " span valid"}, 32'(res_valid), 32'd1);
        check({req, " span kind"}, 32'(res_kind), 32'd0);
        check({req, " span count"}, res_data, exp);
        take_result();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 cmd_ready", 32'(cmd_ready), 32'd1);
        check("R1 res_valid", 32'(res_valid), 32'd0);
        check("R1 capt_pulse", 32'(capt_pulse), 32'd0);
        check("R1 err_flag", 32'(err_flag), 32'd0);
        check("R1 force_valid", 32'(force_valid), 32'd0);

        // R7 table of spans
        for (int i = 0; i < NV; i++) begin
            span(SPANS[i][79:48], SPANS[i][47:16], int'(SPANS[i][15:0]),
                 32'(SPANS[i][15:0]), "R7");
        end

        // R8 saturation at 2^CNT_W-1
        span(32'h6000, 32'h6004, 300, 32'd255, "R8");

        // R11 branch with empty queue
        fetch_valid = 1'b1; fetch_pc = 32'h700; fetch_is_branch = 1'b1;
        #1 check("R11 no force", 32'(force_valid), 32'd0);
        @(negedge clk);
        fetch_valid = 1'b0; fetch_is_branch = 1'b0;
        check("R11 no error", 32'(err_flag), 32'd0);

        // R2/R3 ordering
        send(2'd1, 32'h100, 32'h111, 1'b0);
        send(2'd1, 32'h200, 32'h222, 1'b1);
        fetch_valid = 1'b1; fetch_pc = 32'h100; fetch_is_branch = 1'b1;
        #1 check("R3 first force", 32'(force_valid), 32'd1);
        check("R3 first taken", 32'(force_taken), 32'd0);
        check("R3 first target", force_target, 32'h111);
        @(negedge clk);
        fetch_pc = 32'h200;
        #1 check("R3 second force", 32'(force_valid), 32'd1);
        check("R3 second taken", 32'(force_taken), 32'd1);
        check("R3 second target", force_target, 32'h222);
        @(negedge clk);
        fetch_valid = 1'b0; fetch_is_branch = 1'b0;
        check("R3 no error", 32'(err_flag), 32'd0);

        // R5/R6/R9 capture gated by queue
        send(2'd1, 32'h40, 32'h10, 1'b1);
        send(2'd1, 32'h40, 32'h10, 1'b1);
        send(2'd2, 32'h20, 32'h0, 1'b0);
        #1 check("R9 busy ready", 32'(cmd_ready), 32'd0);
        fetch(32'h20, 1'b0);
        check("R5 held by queue", 32'(capt_pulse), 32'd0);
        check("R5 no early word", 32'(res_valid), 32'd0);
        for (int j = 0; j < 2; j++) begin
            fetch_valid = 1'b1; fetch_pc = 32'h40; fetch_is_branch = 1'b1;
            #1 check("R3 loop force", 32'(force_valid), 32'd1);
            check("R3 loop target", force_target, 32'h10);
            @(negedge clk);
            fetch_valid = 1'b0; fetch_is_branch = 1'b0;
        end
        fetch(32'h20, 1'b0);
        check("R5 pulse", 32'(capt_pulse), 32'd1);
        check("R6 valid", 32'(res_valid), 32'd1);
        check("R6 kind", 32'(res_kind), 32'd1);
        check("R6 data", res_data, 32'h20);
        @(negedge clk);
        check("R5 single pulse", 32'(capt_pulse), 32'd0);
        check("R9 held valid", 32'(res_valid), 32'd1);
        check("R9 held data", res_data, 32'h20);
        check("R9 ready low", 32'(cmd_ready), 32'd0);
        take_result();
        check("R9 released", 32'(res_valid), 32'd0);
        check("R9 ready back", 32'(cmd_ready), 32'd1);

        // R4 mismatch, R10 flush
        send(2'd1, 32'h80, 32'h90, 1'b0);
        fetch_valid = 1'b1; fetch_pc = 32'h84; fetch_is_branch = 1'b1;
        #1 check("R4 no force", 32'(force_valid), 32'd0);
        @(negedge clk);
        fetch_valid = 1'b0; fetch_is_branch = 1'b0;
        check("R4 err set", 32'(err_flag), 32'd1);
        fetch_valid = 1'b1; fetch_pc = 32'h80; fetch_is_branch = 1'b1;
        #1 check("R4 entry kept", 32'(force_valid), 32'd1);
        check("R4 entry target", force_target, 32'h90);
        @(negedge clk);
        fetch_valid = 1'b0; fetch_is_branch = 1'b0;
        check("R4 err sticky", 32'(err_flag), 32'd1);
        send(2'd1, 32'h88, 32'h99, 1'b1);
        send(2'd0, 32'h0, 32'h0, 1'b0);
        check("R10 err cleared", 32'(err_flag), 32'd0);
        fetch_valid = 1'b1; fetch_pc = 32'h88; fetch_is_branch = 1'b1;
        #1 check("R10 queue empty", 32'(force_valid), 32'd0);
        @(negedge clk);
        fetch_valid = 1'b0; fetch_is_branch = 1'b0;

        // R2 full queue
        for (int k = 0; k < 8; k++) send(2'd1, 32'(k * 4 + 32'h1000), 32'h0, 1'b0);
        cmd_op = 2'd1;
        #1 check("R2 full blocks queue", 32'(cmd_ready), 32'd0);
        cmd_op = 2'd3;
        #1 check("R2 full allows other", 32'(cmd_ready), 32'd1);
        cmd_op = 2'd0;
        @(negedge clk);
        fetch_valid = 1'b1; fetch_pc = 32'h1000; fetch_is_branch = 1'b1;
        #1 check("R2 oldest kept", 32'(force_valid), 32'd1);
        @(negedge clk);
        fetch_valid = 1'b0; fetch_is_branch = 1'b0;
        send(2'd0, 32'h0, 32'h0, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule